// File: doc/BRIEF.md
# Phase-Table Time-Sliced Bus Arbiter

This block hands out a bus grant to one of seven masters according to a programmable schedule. Masters are the bridge's own master and six external devices. The schedule is a cyclic table of phases, and each entry holds the 4-bit code of the port that owns that phase. A phase pointer walks the table one step per `phase_tick` and wraps at the end. A port is granted only while it is requesting and only inside a run of at least three consecutive phases that it owns. Grants therefore follow a time-based weighted round-robin, with each port's weight set by how many phases it holds.

The table is double-buffered. Software writes and reads a shadow copy through a simple address/data port, and this has no effect on arbitration. A `load_start` strobe copies the shadow into the active copy at one entry per clock, and `load_busy` is high during the copy. No grants are issued during the copy and ticks are ignored. When the copy ends, the schedule restarts at phase 0.

Top module: `wrr_phase_arbiter`

## Requirements
- R1: Each `phase_tick` seen while no load is running moves the phase pointer forward by one, and it wraps from NUM_PHASES-1 to 0.
- R2: Entry code 0 selects the internal master (`req[0]`/`gnt[0]`). Codes 1 to 6 select external devices 0 to 5 (`req[code]`/`gnt[code]`). Codes 7 to 15 are reserved and never produce a grant.
- R3: A port can be granted only from the third consecutive phase of a run of phases it owns. Runs of one or two phases never grant.
- R4: `gnt` is registered. It is high in the cycle after an edge at which the current phase belongs to a qualifying run whose owner has `req` high. It falls one clock after the request drops or the run ends. A phase owned by a non-requesting port gives no grant.
- R5: At most one `gnt` bit is high at any time.
- R6: Shadow writes take effect at the clock edge where `cfg_we` is high. `cfg_rdata` returns the shadow entry at `cfg_addr` one clock later. Shadow writes do not change grants until a load completes.
- R7: A `load_start` accepted while idle raises `load_busy` for exactly NUM_PHASES+1 cycles. A `load_start` during a load is ignored.
- R8: While a load runs, `gnt` stays zero and ticks are ignored. After the load completes, the pointer is at phase 0 and run counting restarts there.
- R9: After synchronous reset, `gnt` and `load_busy` are zero, the pointer is at phase 0, and every active entry holds a reserved code, so nothing is granted.
- R10: Run counting continues across the wrap from the last phase to phase 0, so a run spanning the wrap qualifies once it reaches three phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_PORTS | Requests; bit 0 internal master, bits 1..6 external devices |
| gnt | output | NUM_PORTS | Registered one-hot grants, same bit order as `req` |
| phase_tick | input | 1 | Advance the phase pointer |
| cfg_we | input | 1 | Shadow table write enable |
| cfg_addr | input | $clog2(NUM_PHASES) | Shadow table entry index |
| cfg_wdata | input | PORT_W | Port code to write |
| cfg_rdata | output | PORT_W | Shadow entry read back, one clock after address |
| load_start | input | 1 | Start copying shadow into active table |
| load_busy | output | 1 | High while the copy runs |

## Verification
The bench builds the arbiter with NUM_PHASES set to 16 and keeps the default seven ports and minimum run of three. With the shorter table, many wraps and many complete loads fit into a short run, so runs that span the wrap, back-to-back reloads and ignored load strobes are all exercised repeatedly. Random tables mix runs of one to five phases with reserved codes, so qualifying and too-short runs both occur near every boundary.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
  localparam int unsigned DEF_PORT_W    = 4;
  localparam int unsigned DEF_NUM_PORTS = 7;
  localparam int unsigned DEF_MIN_RUN   = 3;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wrr_shadow_ram.sv
module wrr_shadow_ram #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned AW    = wrr_arb_pkg::idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [AW-1:0]     ld_addr,
  output logic [DATA_W-1:0] ld_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // software port: write plus read-first registered read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  // loader read port
  always_ff @(posedge clk) begin
    ld_q <= mem[ld_addr];
  end
endmodule

// File: rtl/wrr_active_table.sv
module wrr_active_table #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned AW    = wrr_arb_pkg::idx_width(DEPTH),
  localparam int unsigned CW    = wrr_arb_pkg::idx_width(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  output logic [AW-1:0]     ld_addr,
  input  logic [DATA_W-1:0] ld_q,
  input  logic [AW-1:0]     rd_a_addr,
  output logic [DATA_W-1:0] rd_a_port,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [DATA_W-1:0] rd_b_port,
  output logic              busy,
  output logic              done
);
  localparam logic [DATA_W-1:0] RESERVED_CODE = '1;

  logic [DATA_W-1:0] tbl [DEPTH];
  logic [CW-1:0]     rd_cnt;
  logic              wr_vld;
  logic [AW-1:0]     wr_idx;
  logic              rd_more;

  assign rd_more = (rd_cnt < CW'(DEPTH));
  assign ld_addr = rd_more ? AW'(rd_cnt) : '0;
  assign done    = wr_vld && (wr_idx == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      rd_cnt <= '0;
      wr_vld <= 1'b0;
      wr_idx <= '0;
    end else if (!busy) begin
      if (load_start) begin
        busy   <= 1'b1;
        rd_cnt <= '0;
        wr_vld <= 1'b0;
      end
    end else begin
      wr_vld <= rd_more;
      wr_idx <= AW'(rd_cnt);
      if (rd_more) rd_cnt <= rd_cnt + CW'(1);
      if (done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) tbl[i] <= RESERVED_CODE;
    end else if (busy && wr_vld) begin
      tbl[wr_idx] <= ld_q;
    end
  end

  assign rd_a_port = tbl[rd_a_addr];
  assign rd_b_port = tbl[rd_b_addr];

  // R7: accepted start raises busy
  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (load_start && !busy) |=> busy);
  // R7: busy only rises from an accepted start
  p_busy_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(load_start));
  // R7: busy ends only on the last entry write
  p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(wr_idx) == AW'(DEPTH - 1));
endmodule

// File: rtl/wrr_grant_engine.sv
module wrr_grant_engine #(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned PORT_W    = 4,
  parameter int unsigned NUM_PORTS = 7,
  parameter int unsigned MIN_RUN   = 3,
  localparam int unsigned AW       = wrr_arb_pkg::idx_width(DEPTH),
  localparam int unsigned RW       = wrr_arb_pkg::idx_width(MIN_RUN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 busy,
  input  logic                 load_done,
  input  logic [NUM_PORTS-1:0] req,
  output logic [AW-1:0]        cur_addr,
  input  logic [PORT_W-1:0]    cur_port,
  output logic [AW-1:0]        nxt_addr,
  input  logic [PORT_W-1:0]    nxt_port,
  output logic [NUM_PORTS-1:0] gnt
);
  logic [AW-1:0]        ph;
  logic [RW-1:0]        run;
  logic                 qualified;
  logic [NUM_PORTS-1:0] sel;

  assign cur_addr  = ph;
  assign nxt_addr  = (ph == AW'(DEPTH - 1)) ? '0 : ph + AW'(1);
  assign qualified = (run == RW'(MIN_RUN));

  generate
    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_sel
      assign sel[p] = qualified && (cur_port == PORT_W'(p)) && req[p];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || load_done) begin
      ph  <= '0;
      run <= RW'(1);
    end else if (!busy && tick) begin
      ph <= nxt_addr;
      if (nxt_port != cur_port) run <= RW'(1);
      else if (run != RW'(MIN_RUN)) run <= run + RW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || busy) gnt <= '0;
    else             gnt <= sel;
  end

  // R5: one grant at most
  p_onehot_gnt_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  // R8: no grant following a busy cycle
  p_quiet_load_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> gnt == '0);
  // R3: a grant implies a full run length at the previous edge
  p_min_run_r3: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |-> $past(run) == RW'(MIN_RUN));
  // R1: pointer wraps to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy && !load_done && ph == AW'(DEPTH - 1)) |=> ph == '0);
  // R8: ticks ignored while loading
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !load_done) |=> $stable(ph));

  generate
    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_chk
      // R4: grant requires the request one edge earlier
      p_gnt_req_r4: assert property (@(posedge clk) disable iff (rst)
        gnt[p] |-> $past(req[p]));
    end
  endgenerate
endmodule

// File: rtl/wrr_phase_arbiter.sv
module wrr_phase_arbiter #(
  parameter int unsigned NUM_PHASES = 128,
  parameter int unsigned PORT_W     = wrr_arb_pkg::DEF_PORT_W,
  parameter int unsigned NUM_PORTS  = wrr_arb_pkg::DEF_NUM_PORTS,
  parameter int unsigned MIN_RUN    = wrr_arb_pkg::DEF_MIN_RUN,
  localparam int unsigned AW        = wrr_arb_pkg::idx_width(NUM_PHASES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] gnt,
  input  logic                 phase_tick,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [PORT_W-1:0]    cfg_wdata,
  output logic [PORT_W-1:0]    cfg_rdata,
  input  logic                 load_start,
  output logic                 load_busy
);
  logic [AW-1:0]     ld_addr;
  logic [PORT_W-1:0] ld_q;
  logic [AW-1:0]     cur_addr, nxt_addr;
  logic [PORT_W-1:0] cur_port, nxt_port;
  logic              load_done;

  wrr_shadow_ram #(.DEPTH(NUM_PHASES), .DATA_W(PORT_W)) u_shadow (
    .clk(clk), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .ld_addr(ld_addr), .ld_q(ld_q)
  );

  wrr_active_table #(.DEPTH(NUM_PHASES), .DATA_W(PORT_W)) u_active (
    .clk(clk), .rst(rst), .load_start(load_start),
    .ld_addr(ld_addr), .ld_q(ld_q),
    .rd_a_addr(cur_addr), .rd_a_port(cur_port),
    .rd_b_addr(nxt_addr), .rd_b_port(nxt_port),
    .busy(load_busy), .done(load_done)
  );

  wrr_grant_engine #(
    .DEPTH(NUM_PHASES), .PORT_W(PORT_W),
    .NUM_PORTS(NUM_PORTS), .MIN_RUN(MIN_RUN)
  ) u_engine (
    .clk(clk), .rst(rst), .tick(phase_tick), .busy(load_busy),
    .load_done(load_done), .req(req),
    .cur_addr(cur_addr), .cur_port(cur_port),
    .nxt_addr(nxt_addr), .nxt_port(nxt_port),
    .gnt(gnt)
  );
endmodule

// File: tb/sim_wrr_phase_arbiter.sv
module sim_wrr_phase_arbiter;
  localparam int NPH = 16;
  localparam int NP  = 7;
  localparam int AW  = $clog2(NPH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] req = '0;
  logic [NP-1:0] gnt;
  logic phase_tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_rdata;
  logic load_start = 1'b0;
  logic load_busy;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wrr_phase_arbiter #(.NUM_PHASES(NPH)) u0 (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt), .phase_tick(phase_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .load_start(load_start), .load_busy(load_busy)
  );

  // reference model of the requirements
  logic [3:0] sw [NPH];
  logic [3:0] act [NPH];
  int ph, run, mcnt;
  bit mbusy;
  logic [NP-1:0] exp_gnt;

  function automatic logic [NP-1:0] decide(input logic [3:0] code, input int r,
                                           input logic [NP-1:0] rq);
    logic [NP-1:0] g = '0;
    if (r >= 3 && code < 4'(NP) && rq[code]) g[code] = 1'b1;
    return g;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPH; i++) act[i] = 4'hF;
      ph = 0; run = 1; mbusy = 0; mcnt = 0; exp_gnt = '0;
    end else begin
      if (cfg_we) sw[cfg_addr] = cfg_wdata;
      exp_gnt = mbusy ? '0 : decide(act[ph], run, req);
      if (mbusy) begin
        mcnt++;
        if (mcnt == NPH + 1) begin
          for (int i = 0; i < NPH; i++) act[i] = sw[i];
          ph = 0; run = 1; mbusy = 0;
        end
      end else begin
        if (load_start) begin mbusy = 1; mcnt = 0; end
        if (phase_tick) begin
          int nx;
          nx = (ph + 1) % NPH;
          run = (act[nx] == act[ph]) ? ((run < 3) ? run + 1 : 3) : 1;
          ph = nx;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int actv, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(gnt == exp_gnt, "R2 R3 R4 R5 R10 grant", gnt, exp_gnt);
    chk(load_busy == mbusy, "R7 R8 busy", load_busy, mbusy);
  endtask

  task automatic wr(input int a, input logic [3:0] d);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic do_load(input bit extra_strobe);
    int blen;
    load_start = 1'b1;
    cyc();
    load_start = 1'b0;
    blen = 0;
    while (load_busy && blen < 4 * NPH) begin
      blen++;
      phase_tick = 1'b1;                 // R8: ticks ignored during load
      if (extra_strobe && blen == 3) load_start = 1'b1;  // R7: ignored
      req = '1;
      cyc();
      load_start = 1'b0;
    end
    phase_tick = 1'b0;
    chk(blen == NPH + 1, "R7 busy length", blen, NPH + 1);
  endtask

  task automatic run_random(input int n, input int tick_pct, input int req_pct);
    for (int k = 0; k < n; k++) begin
      phase_tick = (($urandom % 100) < tick_pct);
      for (int b = 0; b < NP; b++) req[b] = (($urandom % 100) < req_pct);
      cyc();
    end
    phase_tick = 1'b0;
  endtask

  task automatic rand_table();
    int i = 0;
    while (i < NPH) begin
      int len, r;
      logic [3:0] code;
      len = 1 + ($urandom % 5);
      r = $urandom % 10;
      code = (r < 8) ? 4'(r % NP) : 4'(7 + ($urandom % 9));
      for (int j = 0; j < len && i < NPH; j++) begin
        wr(i, code);
        i++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    @(negedge clk);
    chk(gnt == '0, "R9 gnt after reset", gnt, 0);
    chk(load_busy == 1'b0, "R9 busy after reset", load_busy, 0);
    req = '1;
    for (int k = 0; k < 2 * NPH; k++) begin
      phase_tick = 1'b1;
      cyc();   // R9: reserved active entries never grant
    end
    phase_tick = 1'b0;

    // directed table: long run, short run, reserved, wrap-spanning run
    for (int i = 0; i < NPH; i++) begin
      logic [3:0] c;
      if (i < 3)        c = 4'd1;   // R3 exact three
      else if (i < 5)   c = 4'd2;   // R3 two never grants
      else if (i < 9)   c = 4'd0;   // R2 internal master
      else if (i < 12)  c = 4'd9;   // R2 reserved
      else if (i < 13)  c = 4'd6;   // single
      else if (i < 14)  c = 4'd5;
      else              c = 4'd3;   // R10 run across wrap
      wr(i, c);
    end
    // R6: read back shadow
    for (int i = 0; i < NPH; i++) begin
      cfg_addr = AW'(i);
      cyc();
      chk(cfg_rdata == sw[i], "R6 readback", cfg_rdata, sw[i]);
    end
    wr(0, 4'd3);  // first entries join the wrap run (R10)
    wr(1, 4'd3);
    do_load(1'b1);
    // R1 R10: every tick, all requesting, several laps
    req = '1;
    for (int k = 0; k < 3 * NPH; k++) begin
      phase_tick = 1'b1;
      cyc();
      phase_tick = 1'b0;
      cyc();
    end
    // R4: request drops mid run
    run_random(200, 60, 50);
    // R6: shadow edits without load leave grants unchanged
    for (int i = 0; i < NPH; i++) wr(i, 4'd4);
    run_random(100, 50, 90);
    do_load(1'b0);
    run_random(100, 50, 90);

    for (int t = 0; t < 12; t++) begin
      rand_table();
      do_load(t[0]);
      run_random(300, 40 + (t * 5) % 50, 40 + (t * 7) % 60);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule